// File: doc/BRIEF.md
# Interrupt Shadow Register File

This block keeps a single saved copy of three core registers: the status flags, the working accumulator and the bank-select register. A snapshot of all three is taken whenever the core vectors to an interrupt, whatever the interrupt's priority, and whenever it executes a call marked as fast. When the core executes a return marked as fast, the block raises a restore enable and presents the saved values, so the core can load them back into its live registers on that same clock edge.

The store has room for one snapshot and no more. Interrupts of both priorities and fast calls all write to the same snapshot. As a result, a high-priority interrupt taken while a low-priority handler is running replaces the values that the low-priority handler saved. The block tracks which event produced the current snapshot and raises a sticky flag when a low-priority snapshot is lost in this way. Software has no read or write path to the saved values.

Top module: `irq_shadow_regs`

## Requirements
- R1: After a synchronous active-low reset, all three restore outputs read zero, and both `restore_en` and `lo_clobbered` are low.
- R2: When `vec_stb` is high at a clock edge, for either value of `vec_hi`, the restore outputs after that edge equal the live inputs sampled at that edge.
- R3: When `call_stb` and `call_fast` are both high at a clock edge, the restore outputs after that edge equal the live inputs sampled at that edge.
- R4: A call with `call_fast` low, or a cycle with no capture strobe, leaves the restore outputs unchanged.
- R5: When `ret_stb` and `ret_fast` are both high and no capture is requested, `restore_en` is high in that same cycle, the restore outputs show the saved snapshot, and the snapshot is unchanged after the edge.
- R6: A return with `ret_fast` low keeps `restore_en` low and leaves the snapshot unchanged.
- R7: When a capture and a fast return are requested in the same cycle, the capture wins: `restore_en` stays low and the snapshot takes the live values.
- R8: The store holds one snapshot only. A second capture replaces the first, and a later fast return presents only the newer values.
- R9: `lo_clobbered` rises one cycle after a vector with `vec_hi` high captures while the current snapshot came from a vector with `vec_hi` low that has not yet been consumed by a fast return. Once set, it stays high until the next capture from a vector with `vec_hi` low, or until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| live_status | input | STATUS_W | Current status register value |
| live_wreg | input | DATA_W | Current working accumulator value |
| live_bank | input | BANK_W | Current bank-select value |
| vec_stb | input | 1 | Interrupt vector taken this cycle |
| vec_hi | input | 1 | Priority tag of the vector: 1 means high, 0 means low |
| call_stb | input | 1 | Call executed this cycle |
| call_fast | input | 1 | The call carries the fast option |
| ret_stb | input | 1 | Return executed this cycle |
| ret_fast | input | 1 | The return carries the fast option |
| rst_status | output | STATUS_W | Saved status value |
| rst_wreg | output | DATA_W | Saved working accumulator value |
| rst_bank | output | BANK_W | Saved bank-select value |
| restore_en | output | 1 | The core loads the restore values this edge |
| lo_clobbered | output | 1 | A low-priority snapshot was overwritten by a high-priority capture |

## Verification
`restore_en` is combinational from the strobes. The bench therefore checks it one nanosecond after it drives the inputs, in the same cycle as the strobe. A capture updates the restore outputs and the clobber flag at the following edge, so the bench compares those at the next falling edge, against a reference model that it advances right after each rising edge. Every cycle, directed or random, compares all five outputs to the model, and the requirement being exercised is named in any mismatch line.

// File: rtl/irq_shadow_pkg.sv
// Shared types for the interrupt shadow register file.
package irq_shadow_pkg;

    // Records which event wrote the current snapshot.
    typedef enum logic [1:0] {
        SNAP_NONE = 2'd0,
        SNAP_LO   = 2'd1,
        SNAP_HI   = 2'd2,
        SNAP_CALL = 2'd3
    } snap_src_e;

endpackage

// File: rtl/shadow_slot.sv
// shadow_slot: one W-bit hidden holding register.
// It loads d on any edge where load is high and keeps its value otherwise.
// It assumes a synchronous active-low reset, which clears it to zero.
module shadow_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold register: cleared by reset, written on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/shadow_ctrl.sv
// shadow_ctrl: turns the strobes into capture and restore commands, and
// tracks which event wrote the snapshot so that a lost low-priority
// snapshot can be flagged.
// It assumes at most one vector per cycle. A capture outranks a fast return.
module shadow_ctrl
    import irq_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vec_stb,
    input  logic vec_hi,
    input  logic call_stb,
    input  logic call_fast,
    input  logic ret_stb,
    input  logic ret_fast,
    output logic capture,
    output logic restore,
    output logic lo_clobbered
);

    snap_src_e owner_q;
    snap_src_e owner_d;
    logic      clob_d;

    // Arbitration: any vector or fast call captures, and a capture blocks a restore.
    always_comb begin
        capture = vec_stb | (call_stb & call_fast);
        restore = ret_stb & ret_fast & ~capture;
    end

    // Next owner tag and next clobber state.
    always_comb begin
        owner_d = owner_q;
        clob_d  = lo_clobbered;
        if (capture) begin
            if (vec_stb)
                owner_d = vec_hi ? SNAP_HI : SNAP_LO;
            else
                owner_d = SNAP_CALL;
        end else if (restore) begin
            owner_d = SNAP_NONE;
        end
        if (vec_stb && vec_hi && owner_q == SNAP_LO)
            clob_d = 1'b1;
        else if (vec_stb && !vec_hi)
            clob_d = 1'b0;
    end

    // State registers for the owner tag and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q      <= SNAP_NONE;
            lo_clobbered <= 1'b0;
        end else begin
            owner_q      <= owner_d;
            lo_clobbered <= clob_d;
        end
    end

endmodule

// File: rtl/irq_shadow_regs.sv
// irq_shadow_regs: one-deep shadow store for status, accumulator and bank
// select. It captures on an interrupt vector or a fast call, and presents the
// snapshot with restore_en on a fast return.
// It assumes that the core loads the rst_* outputs on the edge where
// restore_en is high. The snapshot has no software access path.
module irq_shadow_regs #(
    parameter int STATUS_W = 5,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] live_status,
    input  logic [DATA_W-1:0]   live_wreg,
    input  logic [BANK_W-1:0]   live_bank,
    input  logic                vec_stb,
    input  logic                vec_hi,
    input  logic                call_stb,
    input  logic                call_fast,
    input  logic                ret_stb,
    input  logic                ret_fast,
    output logic [STATUS_W-1:0] rst_status,
    output logic [DATA_W-1:0]   rst_wreg,
    output logic [BANK_W-1:0]   rst_bank,
    output logic                restore_en,
    output logic                lo_clobbered
);

    localparam int SNAP_W = STATUS_W + DATA_W + BANK_W;

    logic              cap_w;
    logic              rest_w;
    logic [SNAP_W-1:0] live_flat;
    logic [SNAP_W-1:0] snap_flat;

    // Pack the live registers into one snapshot word.
    always_comb live_flat = {live_status, live_wreg, live_bank};

    shadow_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_stb      (vec_stb),
        .vec_hi       (vec_hi),
        .call_stb     (call_stb),
        .call_fast    (call_fast),
        .ret_stb      (ret_stb),
        .ret_fast     (ret_fast),
        .capture      (cap_w),
        .restore      (rest_w),
        .lo_clobbered (lo_clobbered)
    );

    shadow_slot #(.W(SNAP_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_w),
        .d     (live_flat),
        .q     (snap_flat)
    );

    // Split the snapshot back into its fields and drive the restore enable.
    always_comb begin
        {rst_status, rst_wreg, rst_bank} = snap_flat;
        restore_en = rest_w;
    end

endmodule

// File: rtl/irq_shadow_chk.sv
// irq_shadow_chk: port-level properties of irq_shadow_regs, attached by bind.
module irq_shadow_chk #(
    parameter int STATUS_W = 5,
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] live_status,
    input logic [DATA_W-1:0]   live_wreg,
    input logic [BANK_W-1:0]   live_bank,
    input logic                vec_stb,
    input logic                vec_hi,
    input logic                call_stb,
    input logic                call_fast,
    input logic                ret_stb,
    input logic                ret_fast,
    input logic [STATUS_W-1:0] rst_status,
    input logic [DATA_W-1:0]   rst_wreg,
    input logic [BANK_W-1:0]   rst_bank,
    input logic                restore_en,
    input logic                lo_clobbered
);

    // R2
    vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_stb |=> (rst_status == $past(live_status) && rst_wreg == $past(live_wreg)
                     && rst_bank == $past(live_bank)));

    // R3
    fcall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb && call_fast) |=> (rst_wreg == $past(live_wreg)
                     && rst_status == $past(live_status) && rst_bank == $past(live_bank)));

    // R4
    no_capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_stb && !(call_stb && call_fast)) |=>
            ($stable(rst_status) && $stable(rst_wreg) && $stable(rst_bank)));

    // R5
    restore_needs_fast_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |-> (ret_stb && ret_fast));

    // R7
    capture_beats_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_stb && ret_stb && ret_fast) |-> !restore_en);

    // R9
    lo_capture_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_stb && !vec_hi) |=> !lo_clobbered);

    // R9
    flag_rise_needs_hi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_clobbered) |-> $past(vec_stb && vec_hi));

endmodule

bind irq_shadow_regs irq_shadow_chk #(
    .STATUS_W (STATUS_W),
    .DATA_W   (DATA_W),
    .BANK_W   (BANK_W)
) u_chk (.*);

// File: tb/irq_shadow_regs_bench.sv
// Bench: a behavioural reference model, compared with the design every cycle.
module irq_shadow_regs_bench;

    localparam int SW = 5;
    localparam int DW = 8;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] live_status;
    logic [DW-1:0] live_wreg;
    logic [BW-1:0] live_bank;
    logic          vec_stb, vec_hi, call_stb, call_fast, ret_stb, ret_fast;
    logic [SW-1:0] rst_status;
    logic [DW-1:0] rst_wreg;
    logic [BW-1:0] rst_bank;
    logic          restore_en, lo_clobbered;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state: the snapshot, its owner (0 none, 1 low, 2 high, 3 call) and the flag.
    int m_st, m_w, m_b, m_owner;
    bit m_flag;

    always #4 clk = ~clk;

    irq_shadow_regs #(.STATUS_W(SW), .DATA_W(DW), .BANK_W(BW)) u_irq_shadow_regs (
        .clk(clk), .rst_n(rst_n), .live_status(live_status), .live_wreg(live_wreg),
        .live_bank(live_bank), .vec_stb(vec_stb), .vec_hi(vec_hi), .call_stb(call_stb),
        .call_fast(call_fast), .ret_stb(ret_stb), .ret_fast(ret_fast),
        .rst_status(rst_status), .rst_wreg(rst_wreg), .rst_bank(rst_bank),
        .restore_en(restore_en), .lo_clobbered(lo_clobbered)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive the inputs, compare all outputs, advance the model at the edge.
    task automatic cyc(input string req, input int st, input int w, input int b,
                       input bit v, input bit vh, input bit c, input bit cf,
                       input bit r, input bit rf);
        bit cap, rest;
        live_status = SW'(st); live_wreg = DW'(w); live_bank = BW'(b);
        vec_stb = v; vec_hi = vh; call_stb = c; call_fast = cf; ret_stb = r; ret_fast = rf;
        cap  = v || (c && cf);
        rest = r && rf && !cap;
        #1;
        check(req, "restore_en", int'(restore_en), (rst_n && rest) ? 1 : 0);
        check(req, "rst_status", int'(rst_status), m_st);
        check(req, "rst_wreg",   int'(rst_wreg),   m_w);
        check(req, "rst_bank",   int'(rst_bank),   m_b);
        check(req, "lo_clobbered", int'(lo_clobbered), int'(m_flag));
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_w = 0; m_b = 0; m_owner = 0; m_flag = 0;
        end else begin
            if (v && vh && m_owner == 1) m_flag = 1;
            else if (v && !vh)           m_flag = 0;
            if (cap) begin
                m_st = st % (1 << SW); m_w = w % (1 << DW); m_b = b % (1 << BW);
                m_owner = v ? (vh ? 2 : 1) : 3;
            end else if (rest) begin
                m_owner = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        cyc(req, 7, 99, 3, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_st = 0; m_w = 0; m_b = 0; m_owner = 0; m_flag = 0;
        rst_n = 1'b0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc("R1", 31, 255, 15, 1, 1, 1, 1, 1, 1);
        rst_n = 1'b1;
        idle("R1");
        check("R1", "direct zero status", int'(rst_status), 0);
        check("R1", "direct zero flag", int'(lo_clobbered), 0);

        // R2: low and high priority vectors capture
        cyc("R2", 5'h15, 8'hA5, 4'h9, 1, 0, 0, 0, 0, 0);
        idle("R2");
        check("R2", "direct wreg after low vector", int'(rst_wreg), 8'hA5);
        cyc("R2", 5'h0A, 8'h3C, 4'h2, 1, 1, 0, 0, 0, 0);
        idle("R2");
        check("R2", "direct bank after high vector", int'(rst_bank), 4'h2);

        // R5: fast return presents the snapshot and keeps it
        cyc("R5", 1, 2, 3, 0, 0, 0, 0, 1, 1);
        idle("R5");
        check("R5", "direct wreg kept after restore", int'(rst_wreg), 8'h3C);

        // R6: plain return
        cyc("R6", 1, 2, 3, 0, 0, 0, 0, 1, 0);
        idle("R6");

        // R4: plain call does not capture
        cyc("R4", 5'h1F, 8'hFF, 4'hF, 0, 0, 1, 0, 0, 0);
        idle("R4");
        check("R4", "direct wreg after plain call", int'(rst_wreg), 8'h3C);

        // R3: fast call captures
        cyc("R3", 5'h11, 8'h77, 4'h5, 0, 0, 1, 1, 0, 0);
        idle("R3");
        cyc("R3", 0, 0, 0, 0, 0, 0, 0, 1, 1);

        // R7: capture and fast return in one cycle
        cyc("R7", 5'h03, 8'h12, 4'h7, 1, 0, 0, 0, 1, 1);
        idle("R7");
        check("R7", "direct wreg after collision", int'(rst_wreg), 8'h12);
        cyc("R7", 5'h04, 8'h34, 4'h8, 0, 0, 1, 1, 1, 1);
        idle("R7");

        // R8: back-to-back captures keep only the newer one
        cyc("R8", 5'h01, 8'h01, 4'h1, 1, 0, 0, 0, 0, 0);
        cyc("R8", 5'h02, 8'h02, 4'h2, 0, 0, 1, 1, 0, 0);
        cyc("R8", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        check("R8", "direct wreg newest", int'(rst_wreg), 8'h02);

        // R9: low vector, then high vector, sets the flag; a later low vector clears it
        cyc("R9", 5'h05, 8'h50, 4'h5, 1, 0, 0, 0, 0, 0);
        cyc("R9", 5'h06, 8'h60, 4'h6, 1, 1, 0, 0, 0, 0);
        check("R9", "direct flag after clobber", int'(lo_clobbered), 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        check("R9", "direct flag sticky", int'(lo_clobbered), 1);
        cyc("R9", 5'h07, 8'h70, 4'h7, 1, 0, 0, 0, 0, 0);
        check("R9", "direct flag cleared", int'(lo_clobbered), 0);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R9", 5'h08, 8'h80, 4'h8, 1, 1, 0, 0, 0, 0);
        check("R9", "direct no flag after consumed low snapshot", int'(lo_clobbered), 0);

        // Random traffic on every input
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 9);
            cyc("R8", $urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 15),
                sel < 3, $urandom_range(0, 1) == 1, sel >= 3 && sel < 6,
                $urandom_range(0, 1) == 1, sel >= 4, $urandom_range(0, 1) == 1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule